// File: doc/BRIEF.md
# HDLC Bit-Level Receive Deframer

This block recovers HDLC frames from a received byte stream. Each accepted input word contributes one byte, taken from a selectable 8-bit lane of the word. The byte is then walked bit by bit, least significant bit first, through a four-state hunt machine. The machine looks for flags, strips stuffed zeros, assembles data bytes and detects aborts. A byte equal to all ones is treated as line idle and resynchronises the machine at once, without its bits being examined.

Completed bytes pass through a two-byte lag stage, so the frame check sequence is never delivered. The running CRC-16 is tested when the closing flag arrives. Each frame ends with an end pulse that carries a good or bad verdict and the data length. A saturating counter records alignment errors, CRC failures, short frames and oversize frames.

The hunt machine has these states. `HS_ZERO` waits for a 0 bit. `HS_FLAGSRCH` waits for a flag. `HS_FLAGSEEN` means a flag has been seen and the first byte is being collected. `HS_INFRAME` means frame bytes are being collected. The transitions are:

- zero-to-search: a 0 bit in `HS_ZERO`.
- flag-hit: in `HS_FLAGSRCH`, a 0 after exactly six 1s.
- first-byte: eight kept bits in `HS_FLAGSEEN`.
- close-aligned: an aligned closing flag in `HS_INFRAME`, back to `HS_FLAGSEEN`.
- close-misaligned: a misaligned closing flag, back to `HS_FLAGSRCH`.
- oversize: a byte beyond the limit, back to `HS_FLAGSRCH`.
- abort: a seventh consecutive 1 in any state other than `HS_ZERO`, back to `HS_ZERO`.
- idle-resync: an all-ones input byte, from any state to `HS_ZERO`.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid`, `out_sof` and `frm_end` are 0, `err_cnt` is 0, and the hunt machine is in zero-search.
- R2: The byte used is `in_word[8*lane_sel+7 : 8*lane_sel]`, so lane 0 is bits 7:0 and lane 1 is bits 15:8. The contents of the other lane have no effect.
- R3: An accepted byte of 0xFF forces zero-search and clears the bit and ones counters, without its bits being processed. If a frame was open, it ends with `frm_end`=1 and `frm_good`=0, and `err_cnt` does not change.
- R4: Bits are taken LSB first. In zero-search, a 0 moves the machine to flag-search. In flag-search, a 0 that follows exactly six 1s is a flag (0x7E) and moves the machine to flag-found.
- R5: Seven consecutive 1s in flag-search, flag-found or frame-found abort and return the machine to zero-search. An open frame ends with `frm_good`=0 and no change to `err_cnt`.
- R6: A 0 that follows exactly five 1s is discarded. Kept bits enter the byte register from the top, so the first kept bit becomes bit 0. A byte completes every 8 kept bits.
- R7: Frame bytes appear on `out_byte` with a one-cycle `out_valid`, and the first one carries `out_sof`. The final two bytes (the FCS) are never delivered, and `out_valid` never coincides with `frm_end`.
- R8: The CRC is reflected CRC-16: polynomial 0x8408, initial value 0xFFFF, run over every byte including the FCS. The FCS is sent complemented, low byte first. An aligned closing flag with residue 0xF0B8 and at least 3 received bytes gives `frm_end`=1, `frm_good`=1 and `frm_len` equal to the number of data bytes.
- R9: An aligned closing flag with a wrong residue, or with fewer than 3 received bytes, gives `frm_end`=1 and `frm_good`=0 and raises `err_cnt` by 1. `err_cnt` never rises by more than 1 per cycle and saturates.
- R10: A closing flag whose bit count since the opening flag is not a multiple of 8 is an alignment error. It gives `frm_end` with `frm_good`=0, raises `err_cnt` by 1 and returns the machine to flag-search.
- R11: A byte completing after MAX_LEN+2 bytes are held is an oversize error. It gives `frm_end` with `frm_good`=0, raises `err_cnt` by 1 and returns the machine to flag-search. The bytes delivered are the first MAX_LEN.
- R12: A closing flag leaves the machine in flag-found, so one flag can both close a frame and open the next.
- R13: A byte is accepted when `in_valid` and `in_ready` are both 1. After a byte other than 0xFF is accepted, `in_ready` stays low for exactly 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | WORD_W | Input word holding the byte lanes |
| lane_sel | input | SEL_W | Lane that carries the received byte |
| out_valid | output | 1 | Delivered frame byte strobe |
| out_byte | output | 8 | Delivered frame byte |
| out_sof | output | 1 | Delivered byte is the first of its frame |
| frm_end | output | 1 | Current frame has terminated |
| frm_good | output | 1 | Terminated frame passed all checks |
| frm_len | output | LEN_W | Data byte count of a good frame, 0 otherwise |
| err_cnt | output | ERR_W | Saturating count of rejected frames |

## Verification
A wrong hunt state or ones count shows at the ports within one frame. Either a good frame fails to produce a `frm_end` with `frm_good`=1 and the expected length, or it delivers bytes shifted by one or more bits. A stray or miscounted stuffed bit corrupts the delivered bytes and the CRC verdict within the same frame, and an alignment counter that is off shows as a spurious `err_cnt` step at the closing flag. Wrong lag-stage contents appear as FCS bytes leaking into `out_byte`, or as a missing first byte at `out_sof`.

// File: rtl/hdlcrx_pkg.sv
package hdlcrx_pkg;

    typedef enum logic [1:0] {
        HS_ZERO     = 2'd0,
        HS_FLAGSRCH = 2'd1,
        HS_FLAGSEEN = 2'd2,
        HS_INFRAME  = 2'd3
    } hunt_state_e;

    localparam logic [15:0] FCS_POLY = 16'h8408;
    localparam logic [15:0] FCS_SEED = 16'hFFFF;
    localparam logic [15:0] FCS_GOOD = 16'hF0B8;

    // One byte through the reflected CRC, LSB first
    function automatic logic [15:0] fcs_step(input logic [15:0] crc_in, input logic [7:0] data);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ FCS_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlcrx_feed.sv
module hdlcrx_feed #(
    parameter int          WORD_W    = 32,
    parameter int          LANES     = 2,
    parameter int          SEL_W     = 1,
    parameter logic [7:0]  IDLE_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic              in_ready,
    output logic              bit_stb,
    output logic              bit_val,
    output logic              resync
);
    localparam int CNT_W = 4;

    logic [7:0]       lane_b [LANES];
    logic [7:0]       pick;
    logic [7:0]       shreg_q;
    logic [CNT_W-1:0] left_q;
    logic             resync_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = in_word[g*8 +: 8];
    end

    always_comb pick = lane_b[lane_sel];

    assign in_ready = (left_q == '0);
    assign bit_stb  = (left_q != '0);
    assign bit_val  = shreg_q[0];
    assign resync   = resync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            left_q   <= '0;
            resync_q <= 1'b0;
        end else begin
            resync_q <= 1'b0;
            if (in_valid && in_ready) begin
                if (pick == IDLE_BYTE) begin
                    resync_q <= 1'b1;
                end else begin
                    shreg_q <= pick;
                    left_q  <= CNT_W'(8);
                end
            end else if (left_q != '0) begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - 1'b1;
            end
        end
    end

    // R13: a non-idle byte blocks the input while its bits are walked
    a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && pick != IDLE_BYTE) |=> !in_ready);

endmodule

// File: rtl/hdlcrx_hunt.sv
module hdlcrx_hunt
    import hdlcrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic       resync,
    input  logic       frame_full,
    output logic       ev_byte,
    output logic [7:0] ev_data,
    output logic       ev_first,
    output logic       ev_close,
    output logic       ev_misalign,
    output logic       ev_toolong,
    output logic       ev_kill
);
    hunt_state_e state_q, state_n;
    logic [2:0]  ones_q, ones_n, ones_inc;
    logic [7:0]  acc_q, acc_n;
    logic [2:0]  nbits_q, nbits_n;
    logic        keep;

    assign ones_inc = (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_ZERO;
            ones_q  <= '0;
            acc_q   <= '0;
            nbits_q <= '0;
        end else begin
            state_q <= state_n;
            ones_q  <= ones_n;
            acc_q   <= acc_n;
            nbits_q <= nbits_n;
        end
    end

    always_comb begin
        state_n     = state_q;
        ones_n      = ones_q;
        acc_n       = acc_q;
        nbits_n     = nbits_q;
        keep        = 1'b0;
        ev_byte     = 1'b0;
        ev_first    = 1'b0;
        ev_close    = 1'b0;
        ev_misalign = 1'b0;
        ev_toolong  = 1'b0;
        ev_kill     = 1'b0;
        if (resync) begin
            ev_kill = (state_q == HS_INFRAME);
            state_n = HS_ZERO;
            ones_n  = '0;
            nbits_n = '0;
        end else if (bit_stb) begin
            unique case (state_q)
                HS_ZERO: begin
                    if (bit_val) begin
                        ones_n = ones_inc;
                    end else begin
                        ones_n  = '0;
                        state_n = HS_FLAGSRCH;
                    end
                end
                HS_FLAGSRCH: begin
                    if (bit_val) begin
                        ones_n = ones_inc;
                        if (ones_q >= 3'd6) state_n = HS_ZERO;
                    end else begin
                        if (ones_q == 3'd6) begin
                            state_n = HS_FLAGSEEN;
                            nbits_n = '0;
                            acc_n   = '0;
                        end
                        ones_n = '0;
                    end
                end
                HS_FLAGSEEN: begin
                    if (bit_val) begin
                        ones_n = ones_inc;
                        if (ones_q >= 3'd6) state_n = HS_ZERO;
                        else                keep    = 1'b1;
                    end else begin
                        if (ones_q == 3'd6) begin
                            nbits_n = '0;
                            acc_n   = '0;
                        end else if (ones_q != 3'd5) begin
                            keep = 1'b1;
                        end
                        ones_n = '0;
                    end
                end
                HS_INFRAME: begin
                    if (bit_val) begin
                        ones_n = ones_inc;
                        if (ones_q >= 3'd6) begin
                            state_n = HS_ZERO;
                            nbits_n = '0;
                            ev_kill = 1'b1;
                        end else begin
                            keep = 1'b1;
                        end
                    end else begin
                        if (ones_q == 3'd6) begin
                            // flag bits 0,1x6 were kept: aligned data leaves 7 here
                            if (nbits_q == 3'd7) begin
                                ev_close = 1'b1;
                                state_n  = HS_FLAGSEEN;
                            end else begin
                                ev_misalign = 1'b1;
                                state_n     = HS_FLAGSRCH;
                            end
                            nbits_n = '0;
                            acc_n   = '0;
                        end else if (ones_q != 3'd5) begin
                            keep = 1'b1;
                        end
                        ones_n = '0;
                    end
                end
            endcase
            if (keep) begin
                acc_n   = {bit_val, acc_q[7:1]};
                nbits_n = nbits_q + 3'd1;
                if (nbits_q == 3'd7) begin
                    if (state_q == HS_FLAGSEEN) begin
                        ev_byte  = 1'b1;
                        ev_first = 1'b1;
                        state_n  = HS_INFRAME;
                    end else if (frame_full) begin
                        ev_toolong = 1'b1;
                        state_n    = HS_FLAGSRCH;
                        nbits_n    = '0;
                    end else begin
                        ev_byte = 1'b1;
                    end
                end
            end
        end
    end

    assign ev_data = acc_n;

    // R3: idle byte lands in zero-search
    a_r3_resync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> state_q == HS_ZERO);
    // R4: zero-search only leaves towards flag-search
    a_r4_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == HS_ZERO |=> (state_q == HS_ZERO || state_q == HS_FLAGSRCH));
    // R5: seventh one aborts
    a_r5_abort_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !resync && bit_val && ones_q >= 3'd6) |=> state_q == HS_ZERO);

endmodule

// File: rtl/hdlcrx_collect.sv
module hdlcrx_collect
    import hdlcrx_pkg::*;
#(
    parameter int MAX_LEN = 32,
    parameter int ERR_W   = 16,
    parameter int LEN_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_byte,
    input  logic [7:0]       ev_data,
    input  logic             ev_first,
    input  logic             ev_close,
    input  logic             ev_misalign,
    input  logic             ev_toolong,
    input  logic             ev_kill,
    output logic             frame_full,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_sof,
    output logic             frm_end,
    output logic             frm_good,
    output logic [LEN_W-1:0] frm_len,
    output logic [ERR_W-1:0] err_cnt
);
    localparam int LAG = 2;
    localparam logic [LEN_W-1:0] HOLD_MAX = LEN_W'(MAX_LEN + LAG);
    localparam logic [LEN_W-1:0] MIN_RX   = LEN_W'(LAG + 1);

    logic [15:0]      crc_q;
    logic [LEN_W-1:0] cnt_q;
    logic [7:0]       hold_q [LAG];
    logic             started_q;
    logic             close_ok;
    logic             err_bump;

    assign frame_full = (cnt_q == HOLD_MAX);
    assign close_ok   = (crc_q == FCS_GOOD) && (cnt_q >= MIN_RX);
    assign err_bump   = (ev_close && !close_ok) || ev_misalign || ev_toolong;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q     <= FCS_SEED;
            cnt_q     <= '0;
            started_q <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sof   <= 1'b0;
            frm_end   <= 1'b0;
            frm_good  <= 1'b0;
            frm_len   <= '0;
            err_cnt   <= '0;
            for (int i = 0; i < LAG; i++) hold_q[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            frm_end   <= 1'b0;
            frm_good  <= 1'b0;
            if (ev_byte) begin
                hold_q[0] <= hold_q[1];
                hold_q[1] <= ev_data;
                if (ev_first) begin
                    crc_q     <= fcs_step(FCS_SEED, ev_data);
                    cnt_q     <= LEN_W'(1);
                    started_q <= 1'b0;
                end else begin
                    crc_q <= fcs_step(crc_q, ev_data);
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q >= LEN_W'(LAG)) begin
                        out_valid <= 1'b1;
                        out_byte  <= hold_q[0];
                        out_sof   <= !started_q;
                        started_q <= 1'b1;
                    end
                end
            end
            if (ev_close) begin
                frm_end  <= 1'b1;
                frm_good <= close_ok;
                frm_len  <= close_ok ? cnt_q - LEN_W'(LAG) : '0;
            end
            if (ev_misalign || ev_toolong || ev_kill) begin
                frm_end <= 1'b1;
                frm_len <= '0;
            end
            if (err_bump && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
        end
    end

    // R8: a good verdict always comes with an end and a non-zero length
    a_r8_good_has_end: assert property (@(posedge clk) disable iff (!rst_n)
        frm_good |-> (frm_end && frm_len != '0));
    // R7: first-byte marker only on a delivered byte
    a_r7_sof_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    // R7: byte delivery and frame end never share a cycle
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && frm_end));
    // R9: error count moves by at most one
    a_r9_err_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
    parameter int  WORD_W  = 32,
    parameter int  LANES   = 2,
    parameter int  MAX_LEN = 32,
    parameter int  ERR_W   = 16,
    localparam int SEL_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int LEN_W   = $clog2(MAX_LEN + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [SEL_W-1:0]  lane_sel,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_sof,
    output logic              frm_end,
    output logic              frm_good,
    output logic [LEN_W-1:0]  frm_len,
    output logic [ERR_W-1:0]  err_cnt
);
    logic       bit_stb, bit_val, resync, frame_full;
    logic       ev_byte, ev_first, ev_close, ev_misalign, ev_toolong, ev_kill;
    logic [7:0] ev_data;

    hdlcrx_feed #(
        .WORD_W   (WORD_W),
        .LANES    (LANES),
        .SEL_W    (SEL_W),
        .IDLE_BYTE(8'hFF)
    ) i_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_word (in_word),
        .lane_sel(lane_sel),
        .in_ready(in_ready),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .resync  (resync)
    );

    hdlcrx_hunt i_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .resync     (resync),
        .frame_full (frame_full),
        .ev_byte    (ev_byte),
        .ev_data    (ev_data),
        .ev_first   (ev_first),
        .ev_close   (ev_close),
        .ev_misalign(ev_misalign),
        .ev_toolong (ev_toolong),
        .ev_kill    (ev_kill)
    );

    hdlcrx_collect #(
        .MAX_LEN(MAX_LEN),
        .ERR_W  (ERR_W),
        .LEN_W  (LEN_W)
    ) i_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_byte    (ev_byte),
        .ev_data    (ev_data),
        .ev_first   (ev_first),
        .ev_close   (ev_close),
        .ev_misalign(ev_misalign),
        .ev_toolong (ev_toolong),
        .ev_kill    (ev_kill),
        .frame_full (frame_full),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_sof    (out_sof),
        .frm_end    (frm_end),
        .frm_good   (frm_good),
        .frm_len    (frm_len),
        .err_cnt    (err_cnt)
    );

endmodule

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;
    localparam int MAXL = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [0:0]  lane_sel = '0;
    logic        out_valid, out_sof, frm_end, frm_good;
    logic [7:0]  out_byte;
    logic [5:0]  frm_len;
    logic [15:0] err_cnt;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .lane_sel(lane_sel), .out_valid(out_valid),
        .out_byte(out_byte), .out_sof(out_sof), .frm_end(frm_end),
        .frm_good(frm_good), .frm_len(frm_len), .err_cnt(err_cnt)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int exp_err = 0;
    bit finished = 1'b0;

    logic [7:0] got_b[$];
    bit         got_s[$];
    bit         end_g[$];
    int         end_l[$];
    logic [7:0] exp_d[$];
    bit         bq[$];
    int         st_ones;
    logic [15:0] crc_s;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin got_b.push_back(out_byte); got_s.push_back(out_sof); end
            if (frm_end) begin end_g.push_back(frm_good); end_l.push_back(int'(frm_len)); end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        got_b.delete(); got_s.delete(); end_g.delete(); end_l.delete();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit lane);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        lane_sel = lane;
        in_word  = lane ? {16'h3CC3, v, 8'hFF} : {16'hA55A, 8'h00, v};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_st(input bit b);
        bq.push_back(b);
        if (b) st_ones++; else st_ones = 0;
        if (st_ones == 5) begin bq.push_back(1'b0); st_ones = 0; end
    endtask

    task automatic put_byte_st(input logic [7:0] v);
        for (int i = 0; i < 8; i++) put_st(v[i]);
    endtask

    task automatic put_flag();
        bq.push_back(1'b0);
        for (int i = 0; i < 6; i++) bq.push_back(1'b1);
        bq.push_back(1'b0);
        st_ones = 0;
    endtask

    task automatic crc_add(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            if (crc_s[0] ^ v[i]) crc_s = (crc_s >> 1) ^ 16'h8408;
            else                 crc_s = crc_s >> 1;
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        if ((i + seed) % 5 == 0) return 8'h7E;
        if ((i + seed) % 7 == 0) return 8'hFF;
        if ((i + seed) % 11 == 0) return 8'h1F;
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic frame_body(input int n, input int seed, input bit bad_fcs, input int extra);
        logic [15:0] fcs;
        exp_d.delete();
        crc_s = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            exp_d.push_back(pat(i, seed));
            crc_add(pat(i, seed));
            put_byte_st(pat(i, seed));
        end
        fcs = ~crc_s;
        if (bad_fcs) fcs = fcs ^ 16'h0100;
        put_byte_st(fcs[7:0]);
        put_byte_st(fcs[15:8]);
        for (int i = 0; i < extra; i++) put_st(1'b0);
    endtask

    task automatic send_stream(input bit lane);
        logic [7:0] v;
        while (bq.size() % 8 != 0) bq.push_back(1'b1);
        for (int k = 0; k < bq.size() / 8; k++) begin
            for (int j = 0; j < 8; j++) v[j] = bq[k*8 + j];
            send_byte(v, lane);
        end
        bq.delete();
        send_byte(8'hFF, lane);
        repeat (20) @(negedge clk);
    endtask

    task automatic check_good(input string tag, input int n);
        int bad = 0;
        int sofs = 0;
        chk(end_g.size() == 1, {tag, " R4 one frame end"}, end_g.size(), 1);
        if (end_g.size() >= 1) begin
            chk(end_g[0] == 1'b1, {tag, " R8 good verdict"}, end_g[0], 1);
            chk(end_l[0] == n, {tag, " R8 length"}, end_l[0], n);
        end
        chk(got_b.size() == n, {tag, " R7 byte count"}, got_b.size(), n);
        for (int i = 0; i < got_b.size() && i < n; i++) if (got_b[i] != exp_d[i]) bad++;
        for (int i = 0; i < got_s.size(); i++) if (got_s[i]) sofs++;
        chk(bad == 0, {tag, " R6 byte values"}, bad, 0);
        chk(sofs == 1 && got_s.size() > 0 && got_s[0], {tag, " R7 sof"}, sofs, 1);
        chk(int'(err_cnt) == exp_err, {tag, " R9 no error"}, err_cnt, exp_err);
        clear_obs();
    endtask

    task automatic check_bad(input string tag, input int nend);
        int goods = 0;
        for (int i = 0; i < end_g.size(); i++) if (end_g[i]) goods++;
        chk(end_g.size() == nend, {tag, " end count"}, end_g.size(), nend);
        chk(goods == 0, {tag, " no good verdict"}, goods, 0);
        chk(int'(err_cnt) == exp_err, {tag, " err_cnt"}, err_cnt, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        st_ones = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(out_valid == 1'b0 && frm_end == 1'b0 && out_sof == 1'b0, "R1 no pulses", out_valid, 0);
        chk(err_cnt == 16'd0, "R1 err_cnt", err_cnt, 0);

        // R13 handshake timing
        send_byte(8'h00, 1'b0);
        n = 0;
        while (!in_ready && n < 50) begin n++; @(negedge clk); end
        chk(n == 8, "R13 busy cycles", n, 8);
        send_byte(8'hFF, 1'b0);
        chk(in_ready == 1'b1, "R13 R3 idle byte keeps ready", in_ready, 1);

        // sweep of lengths and lanes: R2 R4 R6 R7 R8
        for (int len = 1; len <= 12; len++) begin
            for (int ln = 0; ln < 2; ln++) begin
                put_flag(); put_flag();
                frame_body(len, len * 3 + ln, 1'b0, 0);
                put_flag();
                send_stream(ln[0]);
                check_good(ln ? "R2 lane1" : "R2 lane0", len);
            end
        end

        // bad FCS: R9
        put_flag(); frame_body(6, 2, 1'b1, 0); put_flag(); send_stream(1'b0);
        exp_err++;
        check_bad("R9 bad fcs", 1);
        chk(got_b.size() == 6, "R9 bytes still delivered", got_b.size(), 6);
        clear_obs();

        // short frame: R9
        put_flag(); put_byte_st(8'h55); put_flag(); send_stream(1'b0);
        exp_err++;
        check_bad("R9 short frame", 1);
        clear_obs();

        // misaligned closing flag: R10
        put_flag(); frame_body(5, 4, 1'b0, 3); put_flag(); send_stream(1'b1);
        exp_err++;
        check_bad("R10 misaligned", 1);
        clear_obs();
        put_flag(); frame_body(4, 9, 1'b0, 0); put_flag(); send_stream(1'b0);
        check_good("R10 recovery", 4);

        // oversize: R11
        put_flag(); frame_body(MAXL + 8, 1, 1'b0, 0); put_flag(); send_stream(1'b0);
        exp_err++;
        check_bad("R11 oversize", 1);
        begin
            int bad = 0;
            for (int i = 0; i < got_b.size() && i < MAXL; i++) if (got_b[i] != exp_d[i]) bad++;
            chk(got_b.size() == MAXL, "R11 delivered count", got_b.size(), MAXL);
            chk(bad == 0, "R11 delivered bytes", bad, 0);
        end
        clear_obs();

        // maximum length frame is accepted: R11 boundary
        put_flag(); frame_body(MAXL, 6, 1'b0, 0); put_flag(); send_stream(1'b1);
        check_good("R11 at limit", MAXL);

        // abort mid-frame: R5
        put_flag(); frame_body(5, 8, 1'b0, 0);
        bq.push_back(1'b0);
        for (int i = 0; i < 7; i++) bq.push_back(1'b1);
        bq.push_back(1'b0);
        send_stream(1'b0);
        check_bad("R5 abort", 1);
        clear_obs();
        put_flag(); frame_body(3, 5, 1'b0, 0); put_flag(); send_stream(1'b0);
        check_good("R5 recovery", 3);

        // idle byte mid-frame: R3
        put_flag(); frame_body(6, 3, 1'b0, 0);
        send_stream(1'b1);
        check_bad("R3 idle resync", 1);
        clear_obs();

        // shared flag between frames: R12
        put_flag();
        frame_body(4, 12, 1'b0, 0);
        put_flag();
        send_stream_keep();
        frame_body(7, 13, 1'b0, 0);
        put_flag();
        send_stream(1'b0);
        chk(end_g.size() == 2, "R12 two ends", end_g.size(), 2);
        if (end_g.size() == 2) begin
            chk(end_g[0] && end_g[1], "R12 both good", end_g[0] + end_g[1], 2);
            chk(end_l[0] == 4 && end_l[1] == 7, "R12 lengths", end_l[1], 7);
        end
        chk(got_b.size() == 11, "R12 byte count", got_b.size(), 11);
        chk(int'(err_cnt) == exp_err, "R12 R9 err_cnt", err_cnt, exp_err);
        clear_obs();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Sends whole bytes already in the queue without padding or idle byte;
    // the remainder stays queued so the next frame follows the shared flag.
    task automatic send_stream_keep();
        logic [7:0] v;
        while (bq.size() >= 8) begin
            for (int j = 0; j < 8; j++) v[j] = bq[j];
            for (int j = 0; j < 8; j++) void'(bq.pop_front());
            send_byte(v, 1'b0);
        end
    endtask

endmodule